// File: doc/BRIEF.md
# Bit-Slice Register File with Write Shifter

This block is the working store of a 4-bit slice of a microprogrammed ALU. It holds sixteen 4-bit words. Two read ports, addressed independently, return words combinationally, so the ALU can use the values in the same cycle. A single write port always stores into the word selected by the B address. On a rising clock edge, the destination field of the 9-bit microinstruction decides how the ALU result is handled. The result can be kept out of the file. It can be stored as it is. It can be stored after a one-place move toward the least significant bit, or after a one-place move toward the most significant bit.

For a shifted store, the bit that enters the vacated end comes from a serial input pin at that end of the slice. The bit that falls off the other end is presented on a serial output, with an enable, so a neighbouring slice can pick it up. Several slices can then be chained into a wider word. An optional synchronous reset clears every word.

Top module: `rfs_regfile`

## Requirements
- R1: While `rst` is high at a rising edge (and `USE_RESET` is 1), every word is cleared to 0. After that edge, both read ports return 0 for any address.
- R2: When the destination field `instr[8:6]` is 000 or 001, a rising edge leaves every word unchanged.
- R3: When `instr[8:6]` is 010 or 011, a rising edge stores `fIn` unchanged into the word at `addrB`.
- R4: When `instr[8:6]` is 100 or 101, a rising edge stores `{msbIn, fIn[3:1]}` into the word at `addrB`. Example: `fIn`=1001 with `msbIn`=0 stores 0100.
- R5: When `instr[8:6]` is 110 or 111, a rising edge stores `{fIn[2:0], lsbIn}` into the word at `addrB`. Example: `fIn`=0000 with `lsbIn`=1 stores 0001.
- R6: A write changes only the word at `addrB`. Every other word keeps its value and reads back unchanged through either port.
- R7: `rdA` and `rdB` show the words at `addrA` and `addrB` in the same cycle, without a clock. When the two addresses are equal, both ports return the same value.
- R8: During a toward-LSB store (codes 100/101), `lsbOutEn` is 1 and `lsbOut` equals `fIn[0]`. During a toward-MSB store (codes 110/111), `msbOutEn` is 1 and `msbOut` equals `fIn[3]`. In all other cases both enables are 0.
- R9: Instruction bits `instr[6:0]` have no effect on the stored words or on the serial outputs.
- R10: Contents change only at a rising clock edge. Changing `fIn` or `instr` between edges does not alter any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rst | input | 1 | Synchronous clear of all words, active high |
| instr | input | 9 | Microinstruction; bits 8..6 form the destination field |
| fIn | input | 4 | ALU result to be stored |
| addrA | input | 4 | Read address of port A |
| addrB | input | 4 | Read address of port B and write address |
| msbIn | input | 1 | Serial bit entering the MSB on a toward-LSB store |
| lsbIn | input | 1 | Serial bit entering the LSB on a toward-MSB store |
| rdA | output | 4 | Word at addrA |
| rdB | output | 4 | Word at addrB |
| msbOut | output | 1 | Bit shifted out of the MSB on a toward-MSB store |
| msbOutEn | output | 1 | msbOut is valid |
| lsbOut | output | 1 | Bit shifted out of the LSB on a toward-LSB store |
| lsbOutEn | output | 1 | lsbOut is valid |

## Verification
The hardest case to reach from the ports is proving that a store leaves the other fifteen words alone. The ports show only two words at a time, so a corrupting write would stay invisible until the damaged word is read. The stimulus first spreads distinct values over words at both ends of the address range, using every store mode. It then sweeps port A across all sixteen addresses with the file held, and compares each word against the expected image. The same sweep confirms that the hold codes and the instruction bits that should be ignored left no trace.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_DOWN = 2'b01,
    SH_UP   = 2'b10
  } shiftMode_t;

  typedef struct packed {
    logic       wrEn;
    shiftMode_t mode;
  } wrCtl_t;

  localparam int INSTR_W = 9;
  localparam int DEST_HI = 8;
  localparam int DEST_LO = 6;
  localparam int DEST_W  = DEST_HI - DEST_LO + 1;

endpackage

// File: rtl/rfs_ctrl.sv
module rfs_ctrl
  import rfs_pkg::*;
(
  input  logic [1:0] destSel,
  output wrCtl_t     ctl
);

  always_comb begin
    ctl = '{wrEn: 1'b0, mode: SH_NONE};
    unique case (destSel)
      2'b00: ctl = '{wrEn: 1'b0, mode: SH_NONE};
      2'b01: ctl = '{wrEn: 1'b1, mode: SH_NONE};
      2'b10: ctl = '{wrEn: 1'b1, mode: SH_DOWN};
      2'b11: ctl = '{wrEn: 1'b1, mode: SH_UP};
      default: ctl = '{wrEn: 1'b0, mode: SH_NONE};
    endcase
  end

endmodule

// File: rtl/rfs_datapath.sv
module rfs_datapath
  import rfs_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter int DEPTH     = 16,
  parameter bit USE_RESET = 1'b1,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  wrCtl_t            ctl,
  input  logic [WIDTH-1:0]  fIn,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic              msbIn,
  input  logic              lsbIn,
  output logic [WIDTH-1:0]  rdA,
  output logic [WIDTH-1:0]  rdB,
  output logic              msbOut,
  output logic              msbOutEn,
  output logic              lsbOut,
  output logic              lsbOutEn
);

  logic [WIDTH-1:0] wordQ [DEPTH];
  logic [WIDTH-1:0] wrData;
  logic [DEPTH-1:0] wordWe;

  // Shifter folded into the write path
  always_comb begin
    unique case (ctl.mode)
      SH_DOWN: wrData = {msbIn, fIn[WIDTH-1:1]};
      SH_UP:   wrData = {fIn[WIDTH-2:0], lsbIn};
      default: wrData = fIn;
    endcase
  end

  // Serial outputs toward neighbouring slices
  assign lsbOutEn = (ctl.mode == SH_DOWN);
  assign msbOutEn = (ctl.mode == SH_UP);
  assign lsbOut   = lsbOutEn ? fIn[0] : 1'b0;
  assign msbOut   = msbOutEn ? fIn[WIDTH-1] : 1'b0;

  for (genvar g = 0; g < DEPTH; g++) begin : gWord
    assign wordWe[g] = ctl.wrEn && (addrB == ADDR_W'(g));

    always_ff @(posedge clk) begin
      if (USE_RESET && rst) begin
        wordQ[g] <= '0;
      end else if (wordWe[g]) begin
        wordQ[g] <= wrData;
      end
    end
  end

  assign rdA = wordQ[addrA];
  assign rdB = wordQ[addrB];

endmodule

// File: rtl/rfs_regfile.sv
module rfs_regfile
  import rfs_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter int DEPTH     = 16,
  parameter bit USE_RESET = 1'b1,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic [WIDTH-1:0]   fIn,
  input  logic [ADDR_W-1:0]  addrA,
  input  logic [ADDR_W-1:0]  addrB,
  input  logic               msbIn,
  input  logic               lsbIn,
  output logic [WIDTH-1:0]   rdA,
  output logic [WIDTH-1:0]   rdB,
  output logic               msbOut,
  output logic               msbOutEn,
  output logic               lsbOut,
  output logic               lsbOutEn
);

  wrCtl_t ctl;
  logic   unusedInstr;

  // Only the upper two destination bits matter here (R9)
  assign unusedInstr = ^instr[DEST_LO:0];

  rfs_ctrl ctrl_i (
    .destSel (instr[DEST_HI:DEST_HI-1]),
    .ctl     (ctl)
  );

  rfs_datapath #(
    .WIDTH     (WIDTH),
    .DEPTH     (DEPTH),
    .USE_RESET (USE_RESET)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .fIn      (fIn),
    .addrA    (addrA),
    .addrB    (addrB),
    .msbIn    (msbIn),
    .lsbIn    (lsbIn),
    .rdA      (rdA),
    .rdB      (rdB),
    .msbOut   (msbOut),
    .msbOutEn (msbOutEn),
    .lsbOut   (lsbOut),
    .lsbOutEn (lsbOutEn)
  );

endmodule

// File: rtl/rfs_checker.sv
module rfs_checker
  import rfs_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter int DEPTH     = 16,
  parameter bit USE_RESET = 1'b1,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rst,
  input logic [INSTR_W-1:0] instr,
  input logic [WIDTH-1:0]   fIn,
  input logic [ADDR_W-1:0]  addrA,
  input logic [ADDR_W-1:0]  addrB,
  input logic               msbIn,
  input logic               lsbIn,
  input logic [WIDTH-1:0]   rdA,
  input logic [WIDTH-1:0]   rdB,
  input logic               msbOut,
  input logic               msbOutEn,
  input logic               lsbOut,
  input logic               lsbOutEn
);

  logic [1:0] dSel;
  assign dSel = instr[DEST_HI:DEST_HI-1];

  if (USE_RESET) begin : gRst
    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (rdA == '0 && rdB == '0)); // R1
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (dSel == 2'b00) |=> ($stable(addrA) -> $stable(rdA))); // R2

  AST_PASS_STORE: assert property (@(posedge clk) disable iff (rst)
    (dSel == 2'b01) |=> ($stable(addrB) -> rdB == $past(fIn))); // R3

  AST_DOWN_STORE: assert property (@(posedge clk) disable iff (rst)
    (dSel == 2'b10) |=> ($stable(addrB) ->
      rdB == {$past(msbIn), $past(fIn[WIDTH-1:1])})); // R4

  AST_UP_STORE: assert property (@(posedge clk) disable iff (rst)
    (dSel == 2'b11) |=> ($stable(addrB) ->
      rdB == {$past(fIn[WIDTH-2:0]), $past(lsbIn)})); // R5

  AST_OTHER_WORD_KEPT: assert property (@(posedge clk) disable iff (rst)
    (addrA != addrB) |=> ($stable(addrA) -> $stable(rdA))); // R6

  AST_SAME_ADDR_SAME_DATA: assert property (@(posedge clk) disable iff (rst)
    (addrA == addrB) |-> (rdA == rdB)); // R7

  AST_LSB_OUT: assert property (@(posedge clk) disable iff (rst)
    (dSel == 2'b10) |-> (lsbOutEn && !msbOutEn && lsbOut == fIn[0])); // R8

  AST_MSB_OUT: assert property (@(posedge clk) disable iff (rst)
    (dSel == 2'b11) |-> (msbOutEn && !lsbOutEn && msbOut == fIn[WIDTH-1])); // R8

  AST_NO_SERIAL_OUT: assert property (@(posedge clk) disable iff (rst)
    (!dSel[1]) |-> (!msbOutEn && !lsbOutEn)); // R8

endmodule

bind rfs_regfile rfs_checker #(
  .WIDTH     (WIDTH),
  .DEPTH     (DEPTH),
  .USE_RESET (USE_RESET)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .instr    (instr),
  .fIn      (fIn),
  .addrA    (addrA),
  .addrB    (addrB),
  .msbIn    (msbIn),
  .lsbIn    (lsbIn),
  .rdA      (rdA),
  .rdB      (rdB),
  .msbOut   (msbOut),
  .msbOutEn (msbOutEn),
  .lsbOut   (lsbOut),
  .lsbOutEn (lsbOutEn)
);

// File: tb/rfs_regfile_tb_top.sv
`timescale 1ns/1ps
module rfs_regfile_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] instr = '0;
  logic [3:0] fIn = '0;
  logic [3:0] addrA = '0;
  logic [3:0] addrB = '0;
  logic       msbIn = 1'b0;
  logic       lsbIn = 1'b0;
  logic [3:0] rdA, rdB;
  logic       msbOut, msbOutEn, lsbOut, lsbOutEn;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  rfs_regfile dut_i (
    .clk(clk), .rst(rst), .instr(instr), .fIn(fIn),
    .addrA(addrA), .addrB(addrB), .msbIn(msbIn), .lsbIn(lsbIn),
    .rdA(rdA), .rdB(rdB), .msbOut(msbOut), .msbOutEn(msbOutEn),
    .lsbOut(lsbOut), .lsbOutEn(lsbOutEn)
  );

  // Row: dest(3) low(6) f(4) a(4) b(4) msbIn lsbIn expA(4) expB(4)
  //      expPins(4) = {msbOutEn, msbOut, lsbOutEn, lsbOut}
  localparam int NVEC = 11;
  localparam logic [34:0] VEC [NVEC] = '{
    {3'b010, 6'h15, 4'b0111, 4'd0,  4'd0,  1'b0, 1'b0, 4'b0111, 4'b0111, 4'b0000},
    {3'b011, 6'h2A, 4'b1001, 4'd0,  4'd1,  1'b0, 1'b0, 4'b0111, 4'b1001, 4'b0000},
    {3'b000, 6'h3F, 4'b1111, 4'd1,  4'd0,  1'b1, 1'b1, 4'b1001, 4'b0111, 4'b0000},
    {3'b001, 6'h00, 4'b1111, 4'd0,  4'd1,  1'b1, 1'b1, 4'b0111, 4'b1001, 4'b0000},
    {3'b100, 6'h07, 4'b1001, 4'd1,  4'd2,  1'b0, 1'b1, 4'b1001, 4'b0100, 4'b0011},
    {3'b101, 6'h38, 4'b0111, 4'd0,  4'd3,  1'b1, 1'b0, 4'b0111, 4'b1011, 4'b0011},
    {3'b110, 6'h11, 4'b0110, 4'd2,  4'd4,  1'b1, 1'b0, 4'b0100, 4'b1100, 4'b1000},
    {3'b111, 6'h22, 4'b0000, 4'd4,  4'd5,  1'b0, 1'b1, 4'b1100, 4'b0001, 4'b1000},
    {3'b111, 6'h0C, 4'b1101, 4'd5,  4'd15, 1'b1, 1'b0, 4'b0001, 4'b1010, 4'b1100},
    {3'b100, 6'h30, 4'b0011, 4'd15, 4'd14, 1'b1, 1'b0, 4'b1010, 4'b1001, 4'b0011},
    {3'b010, 6'h1B, 4'b1110, 4'd3,  4'd3,  1'b0, 1'b0, 4'b1110, 4'b1110, 4'b0000}
  };

  localparam logic [3:0] FINAL_MEM [16] = '{
    4'b0111, 4'b1001, 4'b0100, 4'b1110, 4'b1100, 4'b0001, 4'b0101, 4'b0000,
    4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1001, 4'b1010
  };

  function automatic string tagOf(input logic [2:0] d);
    case (d[2:1])
      2'b00:   return "R2/R9";
      2'b01:   return "R3/R9";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    #500000;
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    // Reset state, R1
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    addrA = 4'd7; addrB = 4'd15;
    #1;
    check("R1 rdA after reset", rdA, 4'b0000);
    check("R1 rdB after reset", rdB, 4'b0000);
    check("R8 pins idle", {msbOutEn, msbOut, lsbOutEn, lsbOut}, 4'b0000);

    // Vector table: R2..R5, R7, R8, R9
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      instr = {VEC[i][34:32], VEC[i][31:26]};
      fIn   = VEC[i][25:22];
      addrA = VEC[i][21:18];
      addrB = VEC[i][17:14];
      msbIn = VEC[i][13];
      lsbIn = VEC[i][12];
      #1;
      check("R8 serial pins", {msbOutEn, msbOut, lsbOutEn, lsbOut}, VEC[i][3:0]);
      @(posedge clk);
      #1;
      check({tagOf(VEC[i][34:32]), " rdB"}, rdB, VEC[i][7:4]);
      check("R6/R7 rdA", rdA, VEC[i][11:8]);
    end

    // R10: inputs moving between edges do not write
    @(negedge clk);
    instr = 9'b010_000000; addrA = 4'd6; addrB = 4'd6; fIn = 4'b1111;
    #1;
    check("R10 no write before edge", rdB, 4'b0000);
    fIn = 4'b0101;
    #1;
    check("R10 still unwritten", rdA, 4'b0000);
    @(posedge clk);
    #1;
    check("R3 write at edge", rdB, 4'b0101);
    instr = 9'b011_111111; fIn = 4'b0000;
    #1;
    check("R10 no change mid-cycle", rdB, 4'b0101);
    @(negedge clk);
    instr = 9'b000_000000; fIn = 4'b1111;
    @(posedge clk);
    #1;
    check("R2 hold keeps word", rdA, 4'b0101);

    // R9/R2: hold code with every low bit set
    @(negedge clk);
    instr = 9'b001_111111; addrB = 4'd7; addrA = 4'd7; fIn = 4'b1111;
    #1;
    check("R9 no serial out on hold", {msbOutEn, msbOut, lsbOutEn, lsbOut}, 4'b0000);
    @(posedge clk);
    #1;
    check("R9 hold ignores low bits", rdB, 4'b0000);

    // R6: full sweep through port A with the file held
    @(negedge clk);
    instr = 9'b000_000000;
    for (int w = 0; w < 16; w++) begin
      addrA = 4'(w);
      #0.2;
      check($sformatf("R6 word %0d", w), rdA, FINAL_MEM[w]);
    end

    // R1: reset in mid-run clears stored words
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    addrA = 4'd3; addrB = 4'd14;
    #1;
    check("R1 word 3 cleared", rdA, 4'b0000);
    check("R1 word 14 cleared", rdB, 4'b0000);

    finishRun();
  end

endmodule